// File: doc/BRIEF.md
# Oversampling UART Receiver with Automatic Baud Measurement

This block is the receive half of an asynchronous serial port. A 2-flop synchronizer feeds a frame engine that looks for a start bit, votes each bit from three mid-bit samples, shifts in eight data bits LSB first, and checks the stop bit. The sample clock comes from a programmable divisor. Each bit takes 16 sample ticks in normal mode and 4 sample ticks in high-speed mode. Received bytes leave on a valid/ready stream that has one holding stage. Each byte carries a framing-error flag and a break flag.

Software starts automatic baud measurement with a one-cycle strobe. The sender then transmits the sync byte 0x55. The block measures the time from the start-bit falling edge to the fifth falling edge, which is eight bit periods. It converts that time into a divisor with the formula for the selected oversampling factor and loads the divisor itself. The sync byte never reaches the stream, and the sequence raises exactly one receive interrupt, after the sync frame ends.

Stream rules: `m_valid` stays high, with `m_data`, `m_ferr` and `m_brk` stable, until the consumer raises `m_ready`. If a new byte completes while a beat is still held, the new byte is dropped. The held beat is kept, and an overrun is reported.

Top module: `sio_rx_top`

## Requirements
- R1: The sample tick fires once every `div_q`+1 clock cycles. One bit lasts 16 ticks when `hs_sel`=0 and 4 ticks when `hs_sel`=1. A frame is a low start bit, 8 data bits sent LSB first, then the stop bit(s). The byte is received correctly in both modes.
- R2: The frame engine confirms a start bit by a 2-of-3 majority over the three samples around mid-bit. A low pulse shorter than half a bit produces no byte.
- R3: If the checked stop bit is sampled low, the byte is delivered with `m_ferr`=1 and `err_irq` pulses for that byte.
- R4: With `two_stop`=1, the frame engine checks only the second stop bit. A low first stop bit followed by a high second stop bit gives `m_ferr`=0, and the reverse gives `m_ferr`=1.
- R5: If all 8 data bits are 0 and the stop bit is low, the byte is delivered with `m_data`=0x00, `m_ferr`=1 and `m_brk`=1. A line held low delivers only one such byte.
- R6: While `m_valid`=1 and `m_ready`=0, the beat stays stable. A byte that completes during that time is dropped, and `ovr_err` and `err_irq` each pulse once.
- R7: `rx_irq` pulses once for each byte placed on the stream.
- R8: A pulse on `ab_start` raises `ab_active`. The measured count T runs from the first to the fifth falling edge. The loaded divisor is round(T/128)-1 when `hs_sel`=0 and round(T/32)-1 when `hs_sel`=1, and it is exact for integer bit periods.
- R9: During automatic measurement, no byte is delivered. The sequence raises exactly one `rx_irq`, once the line returns high after the sync frame.
- R10: `ab_active` clears itself when the sequence ends. If the measurement counter saturates, or the result does not fit the divisor, `ab_ovf` is set, `ab_active` clears and `div_q` keeps its old value. The next `ab_start` clears `ab_ovf`.
- R11: `div_wr` loads `div_wdata` into `div_q`. Reset sets `div_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| div_wr | input | 1 | Write strobe for the divisor |
| div_wdata | input | DIV_W | Divisor value to write |
| hs_sel | input | 1 | 1 selects 4 samples per bit, 0 selects 16 |
| two_stop | input | 1 | 1 selects two stop bits |
| ab_start | input | 1 | Strobe that starts baud measurement |
| div_q | output | DIV_W | Current divisor |
| ab_active | output | 1 | Baud measurement in progress |
| ab_ovf | output | 1 | Last measurement overflowed |
| m_valid | output | 1 | Stream beat valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 8 | Received byte |
| m_ferr | output | 1 | Framing error for this byte |
| m_brk | output | 1 | Break detected for this byte |
| rx_irq | output | 1 | Receive interrupt pulse |
| err_irq | output | 1 | Error interrupt pulse |
| ovr_err | output | 1 | Overrun pulse |

## Verification
The assertions assume three things about the inputs:
- Software does not write the divisor while a measurement is running.
- `hs_sel` and `two_stop` change only while the line is idle.
- The consumer is the only source of back-pressure.

The stimulus meets these assumptions. It changes mode and divisor only between whole frames with the line high, it pulses `ab_start` only with the line idle, and it holds `m_ready` low only in the overrun scenario.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  typedef enum logic [1:0] {FR_IDLE, FR_START, FR_DATA, FR_STOP} fr_state_e;
  typedef enum logic [1:0] {AB_IDLE, AB_WAIT, AB_MEAS, AB_TAIL} ab_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       ferr;
    logic       brk;
  } rx_beat_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sio_baud_gen.sv
module sio_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // A restart realigns the tick phase to a detected start edge.
  assign tick = (cnt >= div) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart || (cnt >= div)) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
  import sio_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     rx_s,
  input  logic     rx_fall,
  input  logic     tick,
  input  logic     hs_sel,
  input  logic     two_stop,
  output logic     restart,
  output logic     done,
  output rx_beat_t beat
);
  fr_state_e  st;
  logic [3:0] ph;
  logic [2:0] bitn;
  logic       stopn;
  logic [1:0] vs;
  logic [7:0] sh;
  logic [3:0] mid, last;
  logic       decide, v;

  assign mid     = hs_sel ? 4'd2 : 4'd8;
  assign last    = hs_sel ? 4'd3 : 4'd15;
  assign restart = en && (st == FR_IDLE) && rx_fall;
  assign decide  = tick && (st != FR_IDLE) && (ph == mid + 4'd1);
  assign v       = vote3(vs[1], vs[0], rx_s);
  assign done    = en && decide && (st == FR_STOP) && (!two_stop || stopn);
  assign beat    = '{data: sh, ferr: !v, brk: !v && (sh == 8'h00)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= FR_IDLE;
      ph    <= '0;
      bitn  <= '0;
      stopn <= 1'b0;
      vs    <= '0;
      sh    <= '0;
    end else if (!en) begin
      st <= FR_IDLE;
    end else if (restart) begin
      st    <= FR_START;
      ph    <= '0;
      bitn  <= '0;
      stopn <= 1'b0;
    end else if (tick && (st != FR_IDLE)) begin
      ph <= (ph == last) ? 4'd0 : ph + 4'd1;
      if ((ph == mid - 4'd1) || (ph == mid)) vs <= {vs[0], rx_s};
      if (decide) begin
        case (st)
          FR_START: st <= v ? FR_IDLE : FR_DATA;
          FR_DATA: begin
            sh   <= {v, sh[7:1]};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) st <= FR_STOP;
          end
          FR_STOP: begin
            if (two_stop && !stopn) stopn <= 1'b1;
            else                    st    <= FR_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_autobaud.sv
module sio_autobaud
  import sio_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rx_s,
  input  logic             rx_fall,
  input  logic             hs_sel,
  output logic             active,
  output logic             load,
  output logic [DIV_W-1:0] new_div,
  output logic             ovf,
  output logic             fin
);
  localparam int CNT_W = DIV_W + 7;
  localparam logic [CNT_W:0] Q_LIM = (CNT_W+1)'(1) << DIV_W;

  ab_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       nf;
  logic [CNT_W:0]   rnd, q;
  logic             last_edge, q_big, sat;

  // Eight bit periods hold 8*16 or 8*4 ticks; round to nearest, then minus one.
  assign rnd       = {1'b0, cnt} + (hs_sel ? (CNT_W+1)'(16) : (CNT_W+1)'(64));
  assign q         = hs_sel ? (rnd >> 5) : (rnd >> 7);
  assign q_big     = q > Q_LIM;
  assign sat       = &cnt;
  assign last_edge = (st == AB_MEAS) && rx_fall && (nf == 3'd3);
  assign load      = last_edge && !q_big;
  assign new_div   = (q == '0) ? '0 : DIV_W'(q - 1'b1);
  assign fin       = (st == AB_TAIL) && rx_s;
  assign active    = (st != AB_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= AB_IDLE;
      cnt <= '0;
      nf  <= '0;
      ovf <= 1'b0;
    end else if (start) begin
      st  <= AB_WAIT;
      ovf <= 1'b0;
    end else begin
      case (st)
        AB_WAIT: if (rx_fall) begin
          st  <= AB_MEAS;
          cnt <= CNT_W'(1);
          nf  <= '0;
        end
        AB_MEAS: begin
          if (last_edge) begin
            if (q_big) begin
              ovf <= 1'b1;
              st  <= AB_IDLE;
            end else begin
              st <= AB_TAIL;
            end
          end else begin
            if (rx_fall) nf <= nf + 3'd1;
            if (sat) begin
              ovf <= 1'b1;
              st  <= AB_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        AB_TAIL: if (rx_s) st <= AB_IDLE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sio_rx_top.sv
module sio_rx_top
  import sio_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             hs_sel,
  input  logic             two_stop,
  input  logic             ab_start,
  output logic [DIV_W-1:0] div_q,
  output logic             ab_active,
  output logic             ab_ovf,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [7:0]       m_data,
  output logic             m_ferr,
  output logic             m_brk,
  output logic             rx_irq,
  output logic             err_irq,
  output logic             ovr_err
);
  logic [1:0]       rx_sync;
  logic             rx_s, rx_d, rx_fall;
  logic             tick, restart, frm_done;
  logic             ab_load, ab_fin;
  logic [DIV_W-1:0] ab_div;
  rx_beat_t         beat, beat_q;
  logic             take, ovr;

  assign rx_s    = rx_sync[1];
  assign rx_fall = rx_d & ~rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11;
      rx_d    <= 1'b1;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      rx_d    <= rx_s;
    end
  end

  sio_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div_q), .restart(restart), .tick(tick)
  );

  sio_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .en(!ab_active), .rx_s(rx_s), .rx_fall(rx_fall),
    .tick(tick), .hs_sel(hs_sel), .two_stop(two_stop), .restart(restart),
    .done(frm_done), .beat(beat)
  );

  sio_autobaud #(.DIV_W(DIV_W)) u_ab (
    .clk(clk), .rst_n(rst_n), .start(ab_start), .rx_s(rx_s), .rx_fall(rx_fall),
    .hs_sel(hs_sel), .active(ab_active), .load(ab_load), .new_div(ab_div),
    .ovf(ab_ovf), .fin(ab_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (ab_load) div_q <= ab_div;
    else if (div_wr)  div_q <= div_wdata;
  end

  assign take = frm_done && (!m_valid || m_ready);
  assign ovr  = frm_done && m_valid && !m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      beat_q  <= '0;
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
      ovr_err <= 1'b0;
    end else begin
      if (take) begin
        m_valid <= 1'b1;
        beat_q  <= beat;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
      rx_irq  <= take | ab_fin;
      err_irq <= (take && beat.ferr) | ovr;
      ovr_err <= ovr;
    end
  end

  assign m_data = beat_q.data;
  assign m_ferr = beat_q.ferr;
  assign m_brk  = beat_q.brk;
endmodule

// File: rtl/sio_rx_chk.sv
module sio_rx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_q,
  input logic             ab_active,
  input logic             ab_ovf,
  input logic             m_valid,
  input logic             m_ready,
  input logic [7:0]       m_data,
  input logic             m_ferr,
  input logic             m_brk,
  input logic             rx_irq,
  input logic             err_irq,
  input logic             ovr_err
);
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_ferr) && $stable(m_brk));

  p_ovr_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |-> err_irq);

  p_brk_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_brk |-> m_ferr && (m_data == 8'h00));

  p_end_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ab_active) |-> rx_irq || ab_ovf);

  p_no_beat_ab_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ab_active) |-> !$rose(m_valid));

  p_ovf_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ab_ovf) |-> $stable(div_q) && !ab_active);
endmodule

bind sio_rx_top sio_rx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_q(div_q), .ab_active(ab_active), .ab_ovf(ab_ovf),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_ferr(m_ferr),
  .m_brk(m_brk), .rx_irq(rx_irq), .err_irq(err_irq), .ovr_err(ovr_err)
);

// File: tb/sio_rx_top_tb_top.sv
module sio_rx_top_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rxd = 1'b1;
  logic          div_wr = 1'b0;
  logic [DW-1:0] div_wdata = '0;
  logic          hs_sel = 1'b0;
  logic          two_stop = 1'b0;
  logic          ab_start = 1'b0;
  logic [DW-1:0] div_q;
  logic          ab_active, ab_ovf, m_valid, m_ferr, m_brk, rx_irq, err_irq, ovr_err;
  logic          m_ready = 1'b1;
  logic [7:0]    m_data;

  int checks = 0, fails = 0, cyc = 0;
  int beats = 0, rxi = 0, erri = 0, ovri = 0;
  logic [7:0] last_d = '0;
  logic       last_f = 1'b0, last_b = 1'b0;

  always #4 clk = ~clk;

  sio_rx_top #(.DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .div_wr(div_wr), .div_wdata(div_wdata),
    .hs_sel(hs_sel), .two_stop(two_stop), .ab_start(ab_start), .div_q(div_q),
    .ab_active(ab_active), .ab_ovf(ab_ovf), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_ferr(m_ferr), .m_brk(m_brk), .rx_irq(rx_irq),
    .err_irq(err_irq), .ovr_err(ovr_err)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (m_valid && m_ready) begin
        beats  <= beats + 1;
        last_d <= m_data;
        last_f <= m_ferr;
        last_b <= m_brk;
      end
      if (rx_irq)  rxi  <= rxi + 1;
      if (err_irq) erri <= erri + 1;
      if (ovr_err) ovri <= ovri + 1;
    end
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    @(negedge clk); div_wdata = DW'(d); div_wr = 1'b1;
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input int bc, input logic s1,
                            input logic s2, input bit two);
    rxd = 1'b0; idle(bc);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; idle(bc); end
    rxd = s1; idle(bc);
    if (two) begin rxd = s2; idle(bc); end
    rxd = 1'b1; idle(2 * bc);
  endtask

  task automatic pulse_ab();
    @(negedge clk); ab_start = 1'b1;
    @(negedge clk); ab_start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset div_q", int'(div_q), 0);
    chk("R6 reset m_valid", int'(m_valid), 0);
    chk("R10 reset ab_active", int'(ab_active), 0);
    chk("R10 reset ab_ovf", int'(ab_ovf), 0);
  endtask

  task automatic t_16x();
    int b0, r0;
    hs_sel = 1'b0; set_div(3);
    chk("R11 div write", int'(div_q), 3);
    b0 = beats; r0 = rxi;
    send_frame(8'hA5, 64, 1'b1, 1'b1, 1'b0);
    chk("R1 16x byte A5", int'(last_d), 'hA5);
    chk("R3 no ferr", int'(last_f), 0);
    send_frame(8'h3C, 64, 1'b1, 1'b1, 1'b0);
    chk("R1 16x byte 3C", int'(last_d), 'h3C);
    chk("R7 beats", beats - b0, 2);
    chk("R7 rx_irq per byte", rxi - r0, 2);
  endtask

  task automatic t_4x();
    hs_sel = 1'b1; set_div(7);
    send_frame(8'h5A, 32, 1'b1, 1'b1, 1'b0);
    chk("R1 4x byte 5A", int'(last_d), 'h5A);
    send_frame(8'hE1, 32, 1'b1, 1'b1, 1'b0);
    chk("R1 4x byte E1", int'(last_d), 'hE1);
  endtask

  task automatic t_glitch();
    int b0;
    hs_sel = 1'b0; set_div(3);
    b0 = beats;
    rxd = 1'b0; idle(6); rxd = 1'b1; idle(800);
    chk("R2 glitch no byte", beats - b0, 0);
    send_frame(8'h81, 64, 1'b1, 1'b1, 1'b0);
    chk("R2 byte after glitch", int'(last_d), 'h81);
  endtask

  task automatic t_ferr();
    int e0;
    e0 = erri;
    send_frame(8'h3C, 64, 1'b0, 1'b1, 1'b0);
    chk("R3 ferr set", int'(last_f), 1);
    chk("R3 data kept", int'(last_d), 'h3C);
    chk("R3 err_irq", erri - e0, 1);
    chk("R5 no brk on data", int'(last_b), 0);
  endtask

  task automatic t_break();
    int b0;
    b0 = beats;
    rxd = 1'b0; idle(64 * 14); rxd = 1'b1; idle(64 * 3);
    chk("R5 one byte", beats - b0, 1);
    chk("R5 data zero", int'(last_d), 0);
    chk("R5 brk", int'(last_b), 1);
    chk("R5 ferr", int'(last_f), 1);
  endtask

  task automatic t_two_stop();
    hs_sel = 1'b1; two_stop = 1'b1; set_div(7);
    send_frame(8'h96, 32, 1'b0, 1'b1, 1'b1);
    chk("R4 first stop low ignored", int'(last_f), 0);
    chk("R4 data 96", int'(last_d), 'h96);
    send_frame(8'h69, 32, 1'b1, 1'b0, 1'b1);
    chk("R4 second stop low flagged", int'(last_f), 1);
    two_stop = 1'b0;
  endtask

  task automatic t_overrun();
    int o0, e0, b0;
    o0 = ovri; e0 = erri; b0 = beats;
    @(negedge clk); m_ready = 1'b0;
    send_frame(8'h11, 32, 1'b1, 1'b1, 1'b0);
    send_frame(8'h22, 32, 1'b1, 1'b1, 1'b0);
    chk("R6 held valid", int'(m_valid), 1);
    chk("R6 held data", int'(m_data), 'h11);
    chk("R6 ovr pulse", ovri - o0, 1);
    chk("R6 err_irq on ovr", erri - e0, 1);
    m_ready = 1'b1; idle(2);
    chk("R6 drained one", beats - b0, 1);
    chk("R6 drained data", int'(last_d), 'h11);
  endtask

  task automatic t_ab16();
    int b0, r0;
    hs_sel = 1'b0; set_div(0);
    b0 = beats; r0 = rxi;
    pulse_ab();
    chk("R8 active", int'(ab_active), 1);
    rxd = 1'b0; idle(96);
    chk("R9 no irq at start", rxi - r0, 0);
    for (int i = 0; i < 8; i++) begin rxd = (i % 2 == 0); idle(96); end
    rxd = 1'b1; idle(192);
    chk("R8 16x divisor", int'(div_q), 5);
    chk("R10 active cleared", int'(ab_active), 0);
    chk("R9 one irq", rxi - r0, 1);
    chk("R9 sync not delivered", beats - b0, 0);
    send_frame(8'hC3, 96, 1'b1, 1'b1, 1'b0);
    chk("R8 byte at measured rate", int'(last_d), 'hC3);
  endtask

  task automatic t_ab4();
    int r0;
    hs_sel = 1'b1; set_div(1);
    r0 = rxi;
    pulse_ab();
    send_frame(8'h55, 84, 1'b1, 1'b1, 1'b0);
    chk("R8 4x divisor", int'(div_q), 20);
    chk("R9 one irq 4x", rxi - r0, 1);
    send_frame(8'h7E, 84, 1'b1, 1'b1, 1'b0);
    chk("R8 4x byte", int'(last_d), 'h7E);
  endtask

  task automatic t_ovf();
    pulse_ab();
    rxd = 1'b0; idle(33000);
    chk("R10 ovf set", int'(ab_ovf), 1);
    chk("R10 active off", int'(ab_active), 0);
    chk("R10 div kept", int'(div_q), 20);
    rxd = 1'b1; idle(100);
    pulse_ab();
    chk("R10 ovf cleared", int'(ab_ovf), 0);
    send_frame(8'h55, 84, 1'b1, 1'b1, 1'b0);
    chk("R10 recovered", int'(div_q), 20);
  endtask

  initial begin
    idle(3); rst_n = 1'b1; idle(3);
    t_reset();
    t_16x();
    t_4x();
    t_glitch();
    t_ferr();
    t_break();
    t_two_stop();
    t_overrun();
    t_ab16();
    t_ab4();
    t_ovf();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule